// File: doc/BRIEF.md
# Saturating Wide-Dividend Integer Divider

This block divides a double-width dividend by a single-width divisor over many cycles. The dividend's upper half comes from a separate high-word input. Its lower half is the low word of operand A. The divisor is the low word of operand B. The unit handles both unsigned and two's-complement signed division. If the quotient does not fit in one word, the result is clamped to the nearest representable value instead of wrapping, and an overflow flag is raised. A zero divisor raises a trap instead of producing a quotient.

A condition-code select picks the flag-updating variant of the operation. When that variant finishes without a trap, the clamped result and the overflow flag are copied to a separate pair of flag-source outputs. The plain variant leaves those outputs untouched. The remainder is discarded.

Control is a four-state machine:
- `S_IDLE` waits for `start`.
- `S_SETUP` forms the operand magnitudes and tests the divisor.
- `S_ITER` runs one restoring shift-subtract step per cycle.
- `S_FINISH` applies sign and saturation and publishes the result.

The transitions are:
- idle-to-setup on `start`;
- setup-to-finish on a zero divisor;
- setup-to-iterate otherwise;
- iterate-to-iterate until the last step;
- iterate-to-finish after step 2·QW;
- finish-to-idle unconditionally.

Top module: `wide_div_sat`

## Requirements
- R1: The dividend is {hi_word[31:0], op_a[31:0]} and the divisor is op_b[31:0]; bits 63:32 of op_a and op_b have no effect on any output.
- R2: With is_signed=0 and a quotient that fits in 32 bits, quotient is floor(dividend/divisor) and ovf is 0.
- R3: A zero divisor sets div_trap=1, quotient=0 and ovf=0, raises done on the 3rd rising edge counting the edge that samples start as the first, and leaves cc_result and cc_ovf unchanged.
- R4: With is_signed=0 and a true quotient above 0xFFFFFFFF, quotient is 0xFFFFFFFF and ovf is 1.
- R5: With is_signed=1, operands are two's complement and the quotient is truncated toward zero (for example −7/2 gives 0xFFFFFFFD).
- R6: With is_signed=1 and a true quotient below −2^31, quotient is 0x80000000 with ovf=1; above 2^31−1, quotient is 0x7FFFFFFF with ovf=1; exactly −2^31 gives 0x80000000 with ovf=0.
- R7: When cc_sel=1 and no trap occurs, cc_result and cc_ovf take the published quotient and ovf in the cycle done is high; when cc_sel=0 they keep their previous values.
- R8: For a nonzero divisor, done rises on the 67th rising edge counting the edge that samples start as the first; done is high for exactly one cycle.
- R9: A start pulse while an operation is in progress is ignored; the running operation completes with its original operands and timing.
- R10: After reset, quotient, ovf, div_trap, done, cc_result and cc_ovf are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled in idle only) |
| is_signed | input | 1 | 1 = two's-complement division, 0 = unsigned |
| cc_sel | input | 1 | 1 = flag-updating variant |
| hi_word | input | 32 | Upper half of the dividend |
| op_a | input | 64 | Operand A; low 32 bits form the dividend's lower half |
| op_b | input | 64 | Operand B; low 32 bits form the divisor |
| quotient | output | 32 | Saturated quotient, held until the next completion |
| ovf | output | 1 | Quotient was clamped |
| div_trap | output | 1 | Divisor was zero |
| done | output | 1 | One-cycle pulse when the outputs are updated |
| cc_result | output | 32 | Result exported for flag generation |
| cc_ovf | output | 1 | Overflow exported for flag generation |

## Verification
The hardest condition to reach from the ports is a start request that arrives while the shift-subtract loop is running. The stimulus launches a long division and, partway through the iterations, pulses start with very different operands and the opposite signedness. It then checks that the completion comes at the original cycle and carries the original quotient. The signed saturation edges are also only one count apart: −2^31 fits, −2^31−1 clamps, +2^31 clamps, and −2^63/−1 clamps. These are reached with dividends built from all-ones or single-bit high words.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SETUP  = 2'd1,
        S_ITER   = 2'd2,
        S_FINISH = 2'd3
    } wdiv_state_e;

endpackage

// File: rtl/wdiv_prep.sv
// Operand preparation: assembles the double-width dividend, extracts the
// divisor word and converts both to magnitudes for signed operation.
module wdiv_prep #(
    parameter int QW = 32
) (
    input  logic              sgn,
    input  logic [QW-1:0]     hi_in,
    input  logic [QW-1:0]     lo_in,
    input  logic [QW-1:0]     dvs_in,
    output logic [2*QW-1:0]   dvd_mag,
    output logic [QW-1:0]     dvs_mag,
    output logic              res_neg,
    output logic              dvs_zero
);
    localparam int DW = 2 * QW;

    logic [DW-1:0] dvd_raw;
    logic          dvd_neg;
    logic          dvs_neg;

    always_comb begin
        dvd_raw  = {hi_in, lo_in};
        dvd_neg  = sgn & dvd_raw[DW-1];
        dvs_neg  = sgn & dvs_in[QW-1];
        dvd_mag  = dvd_neg ? (~dvd_raw + DW'(1)) : dvd_raw;
        dvs_mag  = dvs_neg ? (~dvs_in + QW'(1)) : dvs_in;
        res_neg  = dvd_neg ^ dvs_neg;
        dvs_zero = (dvs_in == '0);
    end
endmodule

// File: rtl/wdiv_step.sv
// One restoring shift-subtract step: brings the next dividend bit into the
// partial remainder and subtracts the divisor when it fits.
module wdiv_step #(
    parameter int QW = 32
) (
    input  logic [QW:0]       rem_in,
    input  logic [2*QW-1:0]   quo_in,
    input  logic [QW-1:0]     dvs,
    output logic [QW:0]       rem_out,
    output logic [2*QW-1:0]   quo_out
);
    localparam int DW = 2 * QW;

    logic [QW:0] shifted;
    logic [QW:0] diff;
    logic        fits;

    always_comb begin
        shifted = {rem_in[QW-1:0], quo_in[DW-1]};
        diff    = shifted - {1'b0, dvs};
        fits    = (shifted >= {1'b0, dvs});
        rem_out = fits ? diff : shifted;
        quo_out = {quo_in[DW-2:0], fits};
    end
endmodule

// File: rtl/wdiv_clamp.sv
// Applies the result sign and saturates the double-width magnitude into
// one word, flagging when clamping was needed.
module wdiv_clamp #(
    parameter int QW = 32
) (
    input  logic [2*QW-1:0] qmag,
    input  logic            sgn,
    input  logic            neg,
    output logic [QW-1:0]   res,
    output logic            sat
);
    localparam logic [QW-1:0] UMAX = {QW{1'b1}};
    localparam logic [QW-1:0] SMAX = {1'b0, {(QW-1){1'b1}}};
    localparam logic [QW-1:0] SMIN = {1'b1, {(QW-1){1'b0}}};

    logic          upper_set;
    logic [QW-1:0] lo;

    always_comb begin
        lo        = qmag[QW-1:0];
        upper_set = |qmag[2*QW-1:QW];
        if (!sgn) begin
            sat = upper_set;
            res = sat ? UMAX : lo;
        end else if (!neg) begin
            sat = upper_set | lo[QW-1];
            res = sat ? SMAX : lo;
        end else begin
            sat = upper_set | (lo[QW-1] & (|lo[QW-2:0]));
            res = sat ? SMIN : (~lo + QW'(1));
        end
    end
endmodule

// File: rtl/wide_div_sat.sv
module wide_div_sat
    import wdiv_pkg::*;
#(
    parameter int QW  = 32,
    parameter int OPW = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           is_signed,
    input  logic           cc_sel,
    input  logic [QW-1:0]  hi_word,
    input  logic [OPW-1:0] op_a,
    input  logic [OPW-1:0] op_b,
    output logic [QW-1:0]  quotient,
    output logic           ovf,
    output logic           div_trap,
    output logic           done,
    output logic [QW-1:0]  cc_result,
    output logic           cc_ovf
);
    localparam int DW    = 2 * QW;
    localparam int STEPS = DW;
    localparam int CW    = $clog2(STEPS);
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    wdiv_state_e state_q, state_d;

    logic [CW-1:0] cnt_q;
    logic          sgn_q, cc_q, neg_q, zero_q;
    logic [QW-1:0] hi_q, lo_q, dvs_raw_q, dvs_q;
    logic [QW:0]   rem_q;
    logic [DW-1:0] quo_q;
    logic          busy;

    logic [DW-1:0] p_dvd_mag;
    logic [QW-1:0] p_dvs_mag;
    logic          p_neg, p_zero;
    logic [QW:0]   s_rem;
    logic [DW-1:0] s_quo;
    logic [QW-1:0] c_res;
    logic          c_sat;

    // Bits above the word boundary of the operands are deliberately unused.
    logic unused_upper;
    assign unused_upper = ^{op_a[OPW-1:QW], op_b[OPW-1:QW]};

    assign busy = (state_q != S_IDLE);

    wdiv_prep #(.QW(QW)) u_prep (
        .sgn      (sgn_q),
        .hi_in    (hi_q),
        .lo_in    (lo_q),
        .dvs_in   (dvs_raw_q),
        .dvd_mag  (p_dvd_mag),
        .dvs_mag  (p_dvs_mag),
        .res_neg  (p_neg),
        .dvs_zero (p_zero)
    );

    wdiv_step #(.QW(QW)) u_step (
        .rem_in  (rem_q),
        .quo_in  (quo_q),
        .dvs     (dvs_q),
        .rem_out (s_rem),
        .quo_out (s_quo)
    );

    wdiv_clamp #(.QW(QW)) u_clamp (
        .qmag (quo_q),
        .sgn  (sgn_q),
        .neg  (neg_q),
        .res  (c_res),
        .sat  (c_sat)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_SETUP;
            S_SETUP:  state_d = p_zero ? S_FINISH : S_ITER;
            S_ITER:   if (cnt_q == LAST) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            sgn_q     <= 1'b0;
            cc_q      <= 1'b0;
            neg_q     <= 1'b0;
            zero_q    <= 1'b0;
            hi_q      <= '0;
            lo_q      <= '0;
            dvs_raw_q <= '0;
            dvs_q     <= '0;
            rem_q     <= '0;
            quo_q     <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        sgn_q     <= is_signed;
                        cc_q      <= cc_sel;
                        hi_q      <= hi_word;
                        lo_q      <= op_a[QW-1:0];
                        dvs_raw_q <= op_b[QW-1:0];
                    end
                end
                S_SETUP: begin
                    quo_q  <= p_dvd_mag;
                    dvs_q  <= p_dvs_mag;
                    neg_q  <= p_neg;
                    zero_q <= p_zero;
                    rem_q  <= '0;
                    cnt_q  <= '0;
                end
                S_ITER: begin
                    rem_q <= s_rem;
                    quo_q <= s_quo;
                    cnt_q <= cnt_q + CW'(1);
                end
                S_FINISH: ;
                default: ;
            endcase
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quotient  <= '0;
            ovf       <= 1'b0;
            div_trap  <= 1'b0;
            done      <= 1'b0;
            cc_result <= '0;
            cc_ovf    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state_q == S_FINISH) begin
                done <= 1'b1;
                if (zero_q) begin
                    quotient <= '0;
                    ovf      <= 1'b0;
                    div_trap <= 1'b1;
                end else begin
                    quotient <= c_res;
                    ovf      <= c_sat;
                    div_trap <= 1'b0;
                    if (cc_q) begin
                        cc_result <= c_res;
                        cc_ovf    <= c_sat;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/wdiv_chk.sv
module wdiv_chk #(
    parameter int QW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          sgn_q,
    input logic          cc_q,
    input logic          done,
    input logic          ovf,
    input logic          div_trap,
    input logic [QW-1:0] quotient,
    input logic [QW-1:0] cc_result,
    input logic          cc_ovf
);
    localparam logic [QW-1:0] UMAX = {QW{1'b1}};
    localparam logic [QW-1:0] SMAX = {1'b0, {(QW-1){1'b1}}};
    localparam logic [QW-1:0] SMIN = {1'b1, {(QW-1){1'b0}}};

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_start_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r3_trap_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_trap) |-> (quotient == '0 && !ovf));

    a_r4_uns_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf && !sgn_q) |-> (quotient == UMAX));

    a_r6_sgn_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf && sgn_q) |-> (quotient == SMAX || quotient == SMIN));

    a_r7_cc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!done || !cc_q || div_trap) |-> ($stable(cc_result) && $stable(cc_ovf)));

    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(sgn_q) && $stable(cc_q)));
endmodule

bind wide_div_sat wdiv_chk #(.QW(QW)) u_wdiv_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .sgn_q     (sgn_q),
    .cc_q      (cc_q),
    .done      (done),
    .ovf       (ovf),
    .div_trap  (div_trap),
    .quotient  (quotient),
    .cc_result (cc_result),
    .cc_ovf    (cc_ovf)
);

// File: tb/tb_wide_div_sat.sv
module tb_wide_div_sat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_signed = 1'b0;
    logic        cc_sel = 1'b0;
    logic [31:0] hi_word = '0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [31:0] quotient;
    logic        ovf, div_trap, done;
    logic [31:0] cc_result;
    logic        cc_ovf;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] exp_cc_res = '0;
    logic        exp_cc_ovf = 1'b0;

    always #2 clk = ~clk;

    wide_div_sat dut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .cc_sel(cc_sel), .hi_word(hi_word), .op_a(op_a), .op_b(op_b),
        .quotient(quotient), .ovf(ovf), .div_trap(div_trap), .done(done),
        .cc_result(cc_result), .cc_ovf(cc_ovf)
    );

    typedef struct packed {
        logic        sg;
        logic        cc;
        logic [31:0] hi;
        logic [63:0] a;
        logic [63:0] b;
        logic [31:0] q;
        logic        ov;
        logic        tr;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 32'h0,        64'd100,                64'd7,                  32'd14,        1'b0, 1'b0}, // R2
        '{1'b0, 1'b0, 32'h0,        64'h00000000_FFFFFFFF,  64'd1,                  32'hFFFFFFFF,  1'b0, 1'b0}, // R2
        '{1'b0, 1'b1, 32'h1,        64'h0,                  64'd1,                  32'hFFFFFFFF,  1'b1, 1'b0}, // R4
        '{1'b0, 1'b0, 32'h1,        64'h0,                  64'd2,                  32'h80000000,  1'b0, 1'b0}, // R2
        '{1'b0, 1'b1, 32'h3,        64'h0,                  64'd4,                  32'hC0000000,  1'b0, 1'b0}, // R2
        '{1'b1, 1'b0, 32'hFFFFFFFF, 64'h00000000_FFFFFF9C,  64'd7,                  32'hFFFFFFF2,  1'b0, 1'b0}, // R5
        '{1'b1, 1'b1, 32'h0,        64'd100,                64'h00000000_FFFFFFF9,  32'hFFFFFFF2,  1'b0, 1'b0}, // R5
        '{1'b1, 1'b0, 32'hFFFFFFFF, 64'h00000000_FFFFFF9C,  64'h00000000_FFFFFFF9,  32'd14,        1'b0, 1'b0}, // R5
        '{1'b1, 1'b1, 32'h0,        64'h00000000_80000000,  64'd1,                  32'h7FFFFFFF,  1'b1, 1'b0}, // R6
        '{1'b1, 1'b0, 32'hFFFFFFFF, 64'h00000000_80000000,  64'd1,                  32'h80000000,  1'b0, 1'b0}, // R6
        '{1'b1, 1'b1, 32'hFFFFFFFF, 64'h00000000_7FFFFFFF,  64'd1,                  32'h80000000,  1'b1, 1'b0}, // R6
        '{1'b1, 1'b0, 32'h80000000, 64'h0,                  64'h00000000_FFFFFFFF,  32'h7FFFFFFF,  1'b1, 1'b0}, // R6
        '{1'b0, 1'b1, 32'h0,        64'hDEADBEEF_00000064,  64'hFFFF0000_00000007,  32'd14,        1'b0, 1'b0}, // R1
        '{1'b1, 1'b0, 32'hFFFFFFFF, 64'h00000000_FFFFFFF9,  64'd2,                  32'hFFFFFFFD,  1'b0, 1'b0}, // R5
        '{1'b0, 1'b1, 32'h5,        64'h0,                  64'h00000001_00000000,  32'h0,         1'b0, 1'b1}  // R3, R1
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic launch(input vec_t v);
        @(negedge clk);
        is_signed = v.sg; cc_sel = v.cc; hi_word = v.hi; op_a = v.a; op_b = v.b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Returns the ordinal of the rising edge that raised done (edge sampling start = 1).
    task automatic wait_done(output int edges);
        edges = 1;
        while (!done && edges < 300) begin
            @(negedge clk);
            edges++;
        end
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: done never rose, got %0d edges expected <= 67", edges);
        end
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.tr)             return "R3";
        if (v.sg && v.ov)     return "R6";
        if (v.sg)             return "R5";
        if (v.ov)             return "R4";
        if (v.a[63:32] != 0)  return "R1";
        return "R2";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: global timeout, got hang expected completion");
        summary();
        $finish;
    end

    initial begin
        int edges;
        vec_t v;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 quotient", quotient, 32'h0);
        chk("R10 flags", {28'h0, ovf, div_trap, done, cc_ovf}, 32'h0);
        chk("R10 cc_result", cc_result, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            launch(v);
            wait_done(edges);
            chk({tag_of(v), " quotient"}, quotient, v.q);
            chk({tag_of(v), " ovf"}, {31'h0, ovf}, {31'h0, v.ov});
            chk("R3 trap flag", {31'h0, div_trap}, {31'h0, v.tr});
            chk(v.tr ? "R3 latency" : "R8 latency", edges, v.tr ? 3 : 67);
            if (v.cc && !v.tr) begin
                exp_cc_res = v.q;
                exp_cc_ovf = v.ov;
            end
            chk("R7 cc_result", cc_result, exp_cc_res);
            chk("R7 cc_ovf", {31'h0, cc_ovf}, {31'h0, exp_cc_ovf});
            @(negedge clk);
            chk("R8 done one cycle", {31'h0, done}, 32'h0);
        end

        // R9: start while busy is ignored
        launch('{1'b0, 1'b0, 32'h0, 64'd100, 64'd7, 32'd14, 1'b0, 1'b0});
        repeat (10) @(negedge clk);
        is_signed = 1'b1; cc_sel = 1'b1; hi_word = 32'hFFFFFFFF;
        op_a = 64'd1000; op_b = 64'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        edges = 12;
        while (!done && edges < 300) begin
            @(negedge clk);
            edges++;
        end
        chk("R9 busy start quotient", quotient, 32'd14);
        chk("R9 busy start timing", edges, 67);
        chk("R9 no trap", {31'h0, div_trap}, 32'h0);
        chk("R9 cc untouched", cc_result, exp_cc_res);
        @(negedge clk);
        chk("R9 no second done", {31'h0, done}, 32'h0);

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule